// File: doc/BRIEF.md
# Host Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from up to eighteen internal sources into sticky status bits and raises one interrupt line toward a host processor. The host reaches it through a small synchronous register bus. Each register access is a single-cycle strobe with a 3-bit address. Read data is combinational from the current state and valid in the same cycle as the read strobe. Any side effect of the access, such as a mask update or a status clear, takes effect at the next clock edge.

The host can gate each source with a mask. It can rewrite the mask as a whole, or set and clear chosen mask bits through two write-only aliases without a read-modify-write. One status set is visible through two read addresses. The first leaves the bits alone. The second returns them and then clears them all. A write-one acknowledge address clears chosen status bits. An interface configuration register enables the host line and selects its polarity.

Top module: `host_irq_unit`

## Requirements
- R1: After reset the mask reads 0x0000_0001, the status reads 0, the configuration reads 0 and `host_irq` is 0.
- R2: A write to address 0 (mask) loads all 32 mask bits, and a read of address 0 returns them.
- R3: A write to address 1 (mask set) sets each mask bit in [15:0] whose write data bit is 1. Every other mask bit, including all of [31:16], is left unchanged.
- R4: A write to address 2 (mask clear) clears each mask bit in [15:0] whose write data bit is 1. Every other mask bit, including all of [31:16], is left unchanged.
- R5: An event pulse on a source latches a 1 in the status bit of the same index, whether or not that source is masked. The bit is visible from the next cycle. Only positions 0 to 10, 14, 16 and 17 exist. Positions 11, 12, 13 and 15 always read 0.
- R6: A read of address 3 (status view) returns the status and does not change it.
- R7: A read of address 4 (status take) returns the status, and at the following edge every status bit is cleared.
- R8: A write to address 5 (acknowledge) clears each status bit whose write data bit is 1. Bits written as 0 are unaffected. Addresses 1, 2, 5 and 7 read as 0.
- R9: An event that arrives in the same cycle as a take read or an acknowledge of its bit leaves that bit set.
- R10: A source is pending when its status bit is 1 and its mask bit is 0. Masking a source hides it from the line but does not clear its status.
- R11: Address 6 (configuration) holds an enable at bit 5 and an active-low select at bit 7. When enabled, `host_irq` equals pending XOR active-low. When disabled, `host_irq` sits at its inactive level, which equals the active-low bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 18 | One-cycle event pulses, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
The assertions run on every cycle. They check that a latched event survives any clear in its cycle, and that the status holds still when nothing writes or clears it. They also check that a take read with no new event empties the status, and that the set and clear aliases reach exactly the bits they name. Some behaviours only the bench scenarios show. These include that each read address returns the right view and that the upper half of the mask is immune to the aliases. They also include that the unused source positions stay 0 and that the line follows mask, enable and polarity together. The bench checks these against a reference model driven by randomly mixed accesses and events.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  typedef enum logic [2:0] {
    RA_MASK = 3'd0,
    RA_MSET = 3'd1,
    RA_MCLR = 3'd2,
    RA_VIEW = 3'd3,
    RA_TAKE = 3'd4,
    RA_ACK  = 3'd5,
    RA_HCFG = 3'd6
  } reg_addr_e;

  localparam int CFG_EN_BIT  = 5;
  localparam int CFG_LOW_BIT = 7;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int          DATA_W    = 32,
  parameter int          ALIAS_W   = 16,
  parameter logic [31:0] RESET_VAL = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_full,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask
);
  localparam int HI_W = DATA_W - ALIAS_W;

  function automatic logic [DATA_W-1:0] alias_bits(input logic [DATA_W-1:0] d);
    return {{HI_W{1'b0}}, d[ALIAS_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] mask_next(
    input logic [DATA_W-1:0] cur, input logic [DATA_W-1:0] d,
    input logic full, input logic set, input logic clr);
    logic [DATA_W-1:0] n;
    n = cur;
    if (full) n = d;
    else if (set) n = cur | alias_bits(d);
    else if (clr) n = cur & ~alias_bits(d);
    return n;
  endfunction

  logic [DATA_W-1:0] alias_w;
  assign alias_w = alias_bits(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= RESET_VAL[DATA_W-1:0];
    else        mask <= mask_next(mask, wdata, wr_full, wr_set, wr_clr);
  end

  // R3
  mset_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((mask & $past(alias_w)) == $past(alias_w)));

  // R4
  mclr_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((mask & $past(alias_w)) == '0));
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int                 NUM_SRC = 18,
  parameter logic [NUM_SRC-1:0] USED    = 18'h347FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               take_all,
  input  logic               ack_wr,
  input  logic [NUM_SRC-1:0] ack_bits,
  output logic [NUM_SRC-1:0] status,
  output logic               any_evt,
  output logic               any_clr
);
  logic [NUM_SRC-1:0] evt_live;
  logic [NUM_SRC-1:0] clr_vec;

  function automatic logic [NUM_SRC-1:0] status_next(
    input logic [NUM_SRC-1:0] cur, input logic [NUM_SRC-1:0] clr,
    input logic [NUM_SRC-1:0] ev);
    return (cur & ~clr) | ev;
  endfunction

  assign evt_live = evt & USED;
  assign clr_vec  = take_all ? {NUM_SRC{1'b1}} : (ack_wr ? ack_bits : '0);
  assign any_evt  = |evt_live;
  assign any_clr  = |clr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_next(status, clr_vec, evt_live);
  end

  // R9
  evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> ((status & $past(evt_live)) == $past(evt_live)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_evt && !any_clr) |=> $stable(status));

  // R7
  take_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_all && !any_evt) |=> (status == '0));
endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive #(
  parameter int NUM_SRC = 18
) (
  input  logic [NUM_SRC-1:0] status,
  input  logic [NUM_SRC-1:0] mask,
  input  logic               enable,
  input  logic               act_low,
  output logic               pending,
  output logic               irq
);
  logic [NUM_SRC-1:0] gated;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_gate
    assign gated[k] = status[k] & ~mask[k];
  end

  assign pending = |gated;
  assign irq     = enable ? (pending ^ act_low) : act_low;
endmodule

// File: rtl/host_irq_unit.sv
module host_irq_unit #(
  parameter int                 NUM_SRC = 18,
  parameter int                 DATA_W  = 32,
  parameter int                 ALIAS_W = 16,
  parameter int                 ADDR_W  = 3,
  parameter logic [NUM_SRC-1:0] USED    = 18'h347FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              host_irq
);
  import hirq_pkg::*;

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic               wr_mask, wr_mset, wr_mclr, wr_ack, wr_cfg, rd_take;
  logic [DATA_W-1:0]  mask;
  logic [NUM_SRC-1:0] status;
  logic               any_evt, any_clr, pending;
  logic               cfg_en, cfg_low;

  assign wr_mask = bus_wr && (bus_addr == RA_MASK);
  assign wr_mset = bus_wr && (bus_addr == RA_MSET);
  assign wr_mclr = bus_wr && (bus_addr == RA_MCLR);
  assign wr_ack  = bus_wr && (bus_addr == RA_ACK);
  assign wr_cfg  = bus_wr && (bus_addr == RA_HCFG);
  assign rd_take = bus_rd && (bus_addr == RA_TAKE);

  irq_mask_reg #(.DATA_W(DATA_W), .ALIAS_W(ALIAS_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_full(wr_mask), .wr_set(wr_mset),
    .wr_clr(wr_mclr), .wdata(bus_wdata), .mask(mask));

  irq_status_bank #(.NUM_SRC(NUM_SRC), .USED(USED)) u_sts (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .take_all(rd_take),
    .ack_wr(wr_ack), .ack_bits(bus_wdata[NUM_SRC-1:0]),
    .status(status), .any_evt(any_evt), .any_clr(any_clr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en  <= 1'b0;
      cfg_low <= 1'b0;
    end else if (wr_cfg) begin
      cfg_en  <= bus_wdata[CFG_EN_BIT];
      cfg_low <= bus_wdata[CFG_LOW_BIT];
    end
  end

  irq_line_drive #(.NUM_SRC(NUM_SRC)) u_line (
    .status(status), .mask(mask[NUM_SRC-1:0]), .enable(cfg_en),
    .act_low(cfg_low), .pending(pending), .irq(host_irq));

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_MASK: bus_rdata = mask;
      RA_VIEW,
      RA_TAKE: bus_rdata = {{PAD_W{1'b0}}, status};
      RA_HCFG: begin
        bus_rdata[CFG_EN_BIT]  = cfg_en;
        bus_rdata[CFG_LOW_BIT] = cfg_low;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R10
  masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_clr && (status != '0)) |=> ((status & $past(status)) == $past(status)));
endmodule

// File: tb/test_host_irq_unit.sv
module test_host_irq_unit;
  localparam logic [17:0] USED = 18'h347FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] evt_i = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        host_irq;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [31:0] m_mask;
  logic [17:0] m_sts;
  logic        m_en, m_low;

  host_irq_unit i_host_irq_unit (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .host_irq(host_irq));

  always #4 clk = ~clk;

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0:    return m_mask;
      3'd3:    return {14'd0, m_sts};
      3'd4:    return {14'd0, m_sts};
      3'd6:    return {24'd0, m_low, 1'b0, m_en, 5'd0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic p;
    p = |(m_sts & ~m_mask[17:0]);
    return m_en ? (p ^ m_low) : m_low;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic rd, input logic [2:0] a,
                    input logic [31:0] d, input logic [17:0] ev, input string tag);
    logic [17:0] clr;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; evt_i = ev;
    #1;
    chk({tag, " line"}, {31'd0, host_irq}, {31'd0, exp_irq()});
    if (rd) chk({tag, " read"}, bus_rdata, exp_rd(a));
    @(posedge clk);
    clr = (rd && a == 3'd4) ? 18'h3FFFF : ((wr && a == 3'd5) ? d[17:0] : 18'd0);
    m_sts = (m_sts & ~clr) | (ev & USED);
    if (wr) begin
      case (a)
        3'd0: m_mask = d;
        3'd1: m_mask = m_mask | {16'd0, d[15:0]};
        3'd2: m_mask = m_mask & ~{16'd0, d[15:0]};
        3'd6: begin m_en = d[5]; m_low = d[7]; end
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    m_mask = 32'h1; m_sts = '0; m_en = 0; m_low = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    op(0, 1, 3'd0, 0, 0, "R1 mask");
    op(0, 1, 3'd3, 0, 0, "R1 status");
    op(0, 1, 3'd6, 0, 0, "R1 cfg");
    chk("R1 irq", {31'd0, host_irq}, 32'd0);
    // R2 full mask write
    op(1, 0, 3'd0, 32'hDEAD_BEEF, 0, "R2 wr");
    op(0, 1, 3'd0, 0, 0, "R2 rd");
    // R3 / R4 aliases, upper half untouched
    op(1, 0, 3'd0, 32'h5A00_0000, 0, "R3 base");
    op(1, 0, 3'd1, 32'hFFFF_00F0, 0, "R3 set");
    op(0, 1, 3'd0, 0, 0, "R3 rd");
    op(1, 0, 3'd2, 32'hFFFF_0030, 0, "R4 clr");
    op(0, 1, 3'd0, 0, 0, "R4 rd");
    op(0, 1, 3'd1, 0, 0, "R8 wo read mset");
    op(0, 1, 3'd7, 0, 0, "R8 wo read spare");
    // R5 all events, unused positions stay 0
    op(0, 0, 3'd0, 0, 18'h3FFFF, "R5 evt");
    op(0, 1, 3'd3, 0, 0, "R5 view");
    // R6 view twice
    op(0, 1, 3'd3, 0, 0, "R6 view again");
    // R8 ack
    op(1, 0, 3'd5, 32'h0000_0003, 0, "R8 ack");
    op(1, 0, 3'd5, 32'h0, 0, "R8 ack zero");
    op(0, 1, 3'd3, 0, 0, "R8 view");
    op(0, 1, 3'd5, 0, 0, "R8 wo read ack");
    // R7 take
    op(0, 1, 3'd4, 0, 0, "R7 take");
    op(0, 1, 3'd3, 0, 0, "R7 after");
    // R9 collisions
    op(0, 0, 3'd0, 0, 18'h00028, "R9 seed");
    op(0, 1, 3'd4, 0, 18'h00008, "R9 take+evt");
    op(0, 1, 3'd3, 0, 0, "R9 view");
    op(1, 0, 3'd5, 32'h8, 18'h00008, "R9 ack+evt");
    op(0, 1, 3'd3, 0, 0, "R9 view2");
    // R10 / R11 line control
    op(1, 0, 3'd0, 32'hFFFF_FFFF, 0, "R10 mask all");
    op(1, 0, 3'd6, 32'h20, 0, "R11 enable");
    op(0, 1, 3'd3, 0, 0, "R10 masked kept");
    op(1, 0, 3'd2, 32'h8, 0, "R10 unmask 3");
    op(1, 0, 3'd6, 32'hA0, 0, "R11 active low");
    op(1, 0, 3'd6, 32'h80, 0, "R11 disabled low");
    op(1, 0, 3'd6, 32'h00, 0, "R11 disabled high");
    op(0, 1, 3'd6, 0, 0, "R11 cfg rd");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0]  a;
      logic        w;
      logic [17:0] ev;
      a  = 3'($urandom % 8);
      w  = 1'($urandom % 2);
      ev = 18'($urandom & $urandom & $urandom);
      op(w, !w, a, $urandom, ev, "R2..R11 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule